// File: doc/BRIEF.md
# Bus Cycle Break Condition Comparator

This block watches every bus cycle issued by the processor or by the DMA engine and flags the cycles that meet a programmed break condition. It has two independent channels, A and B. Each channel holds a target address, an address ignore mask, and a condition word. The condition word selects the operand size, the kind of cycle (instruction fetch or data access), the direction (read or write) and which bus master may trigger it. Channel B also holds a data value and a data ignore mask, so a data-access break can additionally require a match on the transferred value.

The address compare is aligned to the size of the access. A longword access is compared on bits 31..2, a word on bits 31..1 and a byte on every bit. A single break address therefore catches every access that covers the addressed byte. For a data condition the block picks the active byte lane or halfword lane of the bus from the low address bits. It compares that lane against the low half of the data register, so software places a byte value in both of the two low register bytes.

Each channel drives a registered one-clock match pulse and sets a sticky status bit. Software configures the block through a simple word-addressed register port with combinational readback.

Top module: `bus_break_cmp`

## Requirements
- R1: The address compare ignores bits 1..0 for a longword access (busSize 11), bit 0 for a word access (busSize 10), and no bits for a byte access (busSize 01). A bus size of 00 never matches.
- R2: With the condition size field left at 00 (any size) and a break address of 0x00001003, a longword access at 0x00001000, a word access at 0x00001002 and a byte access at 0x00001003 all match. A byte access at 0x00001002 and a word access at 0x00001000 do not.
- R3: Every bit set to 1 in a channel's address mask register (offsets 1 and 4) is excluded from the address compare, on top of the size-based low-bit exclusion.
- R4: Condition bits 1..0 select the size: 00 any, 01 byte, 10 word, 11 longword. When the field is not 00, only an access of exactly that size can match.
- R5: Condition bits 3..2 allow fetch (bit 2) and data (bit 3) cycles. Bits 5..4 allow reads (bit 4) and writes (bit 5). Bits 7..6 allow the processor (bit 6) and DMA (bit 7) as master. A cycle whose kind, direction or master has its allow bit clear never matches.
- R6: When channel B condition bit 8 is set, a data cycle matches only if the address condition holds and the bus data equals the data register (offset 6) on every bit whose data mask (offset 7) bit is 0. A longword compares all 32 bits. A word compares register bits 15..0 against the halfword lane picked by address bit 1, and register bits 31..16 have no effect.
- R7: For a byte data condition, the bus byte lane picked by address bits 1..0 is compared against register bits 15..8 when address bit 0 is 1, and against bits 7..0 when it is 0.
- R8: A channel B data condition with size field 00 never matches.
- R9: On a fetch cycle channel B skips the data compare entirely, and a match then depends on the address and cycle conditions only.
- R10: A DMA cycle never matches a channel whose size field is longword. A DMA cycle never matches a channel B data condition unless its size is byte or word.
- R11: Outputs matchA and matchB rise in the clock cycle after a bus cycle presented with busValid high meets that channel's condition, and last exactly one clock. With busValid low there is no match.
- R12: Status register (offset 8) bit 0 (channel A) and bit 1 (channel B) are set by a match pulse and stay set. Writing the register clears each bit written as 0 and leaves each bit written as 1 unchanged. A new match wins over a clear in the same cycle.
- R13: All registers reset to zero and read back at their offsets: 0/1/2 for channel A address/mask/condition, 3/4/5 for channel B, 6 data, 7 data mask, 8 status. Channel A condition bit 8 always reads 0. With a zero condition no cycle matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational readback of the register at regAddr |
| busValid | input | 1 | A bus cycle is present this clock |
| busAddr | input | ADDR_W | Bus cycle address |
| busData | input | 32 | Bus cycle data, byte lanes by address |
| busSize | input | 2 | Access size: 01 byte, 10 word, 11 longword |
| busFetch | input | 1 | 1 for instruction fetch, 0 for data access |
| busWrite | input | 1 | 1 for write, 0 for read |
| busDma | input | 1 | 1 when the DMA engine is master |
| matchA | output | 1 | One-clock channel A match pulse |
| matchB | output | 1 | One-clock channel B match pulse |

## Verification
A corrupted address, mask or condition register shows up at regRdData the clock after the write. At the match outputs it shows one clock after the first bus cycle that the corrupted field decides, as a missing or extra pulse. A wrong lane or size selection inside the comparator is only visible when the access size and low address bits route through that lane. For this reason the directed scenarios sweep all three sizes, both halfword lanes and several byte lanes against values that differ lane by lane. A status bit stuck high or low appears at readback two clocks after the pulse that should have set it, or one clock after a clearing write.

// File: rtl/bbc_pkg.sv
package bbc_pkg;
  localparam int DATA_W = 32;
  localparam int NUM_CH = 2;
  localparam int REG_AW = 4;
  localparam int CH_REGS = 3;
  localparam int OFF_DATA = 6;
  localparam int OFF_DMASK = 7;
  localparam int OFF_STATUS = 8;

  typedef enum logic [1:0] {
    SZ_ANY  = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10,
    SZ_LONG = 2'b11
  } size_e;

  // bit 8 dataEn, 7..6 master {dma,cpu}, 5..4 dir {write,read},
  // 3..2 kind {data,fetch}, 1..0 size
  typedef struct packed {
    logic       dataEn;
    logic [1:0] master;
    logic [1:0] dir;
    logic [1:0] kind;
    size_e      size;
  } cond_t;

  localparam int COND_W = $bits(cond_t);

  typedef struct packed {
    logic [NUM_CH-1:0] wrAddr;
    logic [NUM_CH-1:0] wrMask;
    logic [NUM_CH-1:0] wrCond;
    logic              wrData;
    logic              wrDmask;
    logic              wrStatus;
  } strobe_t;
endpackage

// File: rtl/bbc_chan_cmp.sv
module bbc_chan_cmp
  import bbc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter bit HAS_DATA = 1'b0
) (
  input  logic [ADDR_W-1:0] addrReg,
  input  logic [ADDR_W-1:0] maskReg,
  input  cond_t             cond,
  input  logic [DATA_W-1:0] dataReg,
  input  logic [DATA_W-1:0] dmaskReg,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic [1:0]        busSize,
  input  logic              busFetch,
  input  logic              busWrite,
  input  logic              busDma,
  output logic              hit
);
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  logic [ADDR_W-1:0] addrIgn;
  logic              sizeKnown;
  logic              sizeOk;
  logic              addrOk;
  logic              attrOk;
  logic              dataUse;
  logic              dmaOk;
  logic              dataSizeOk;
  logic              dataOk;
  logic [BYTE_W-1:0] busByte;
  logic [HALF_W-1:0] busHalf;
  logic [DATA_W-1:0] busSel;
  logic [DATA_W-1:0] refSel;
  logic [DATA_W-1:0] ignSel;

  // Address: size-aligned low bits plus the software mask
  always_comb begin
    addrIgn = maskReg;
    sizeKnown = 1'b1;
    unique case (busSize)
      SZ_LONG: addrIgn[1:0] = 2'b11;
      SZ_WORD: addrIgn[0]   = 1'b1;
      SZ_BYTE: ;
      default: sizeKnown = 1'b0;
    endcase
  end

  assign addrOk = ((busAddr ^ addrReg) & ~addrIgn) == '0;
  assign sizeOk = (cond.size == SZ_ANY) || (cond.size == busSize);

  // Cycle attributes: one allow bit per alternative
  assign attrOk = (busFetch ? cond.kind[0] : cond.kind[1]) &&
                  (busWrite ? cond.dir[1] : cond.dir[0]) &&
                  (busDma ? cond.master[1] : cond.master[0]);

  assign dataUse    = HAS_DATA && cond.dataEn && !busFetch;
  assign dataSizeOk = !dataUse || (cond.size != SZ_ANY);
  assign dmaOk      = !busDma || (cond.size != SZ_LONG);

  // Lane selection for the data compare
  assign busByte = busData[{busAddr[1:0], 3'b000} +: BYTE_W];
  assign busHalf = busAddr[1] ? busData[HALF_W +: HALF_W] : busData[0 +: HALF_W];

  always_comb begin
    unique case (busSize)
      SZ_BYTE: begin
        busSel = {{(DATA_W-BYTE_W){1'b0}}, busByte};
        refSel = {{(DATA_W-BYTE_W){1'b0}},
                  busAddr[0] ? dataReg[BYTE_W +: BYTE_W] : dataReg[0 +: BYTE_W]};
        ignSel = {{(DATA_W-BYTE_W){1'b0}},
                  busAddr[0] ? dmaskReg[BYTE_W +: BYTE_W] : dmaskReg[0 +: BYTE_W]};
      end
      SZ_WORD: begin
        busSel = {{(DATA_W-HALF_W){1'b0}}, busHalf};
        refSel = {{(DATA_W-HALF_W){1'b0}}, dataReg[0 +: HALF_W]};
        ignSel = {{(DATA_W-HALF_W){1'b0}}, dmaskReg[0 +: HALF_W]};
      end
      default: begin
        busSel = busData;
        refSel = dataReg;
        ignSel = dmaskReg;
      end
    endcase
  end

  assign dataOk = ((busSel ^ refSel) & ~ignSel) == '0;

  assign hit = sizeKnown && sizeOk && addrOk && attrOk && dmaOk &&
               dataSizeOk && (!dataUse || dataOk);
endmodule

// File: rtl/bbc_datapath.sv
module bbc_datapath
  import bbc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        strb,
  input  logic [DATA_W-1:0]              wrData,
  input  logic                           busValid,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic [DATA_W-1:0]              busData,
  input  logic [1:0]                     busSize,
  input  logic                           busFetch,
  input  logic                           busWrite,
  input  logic                           busDma,
  output logic [NUM_CH-1:0][ADDR_W-1:0]  addrQ,
  output logic [NUM_CH-1:0][ADDR_W-1:0]  maskQ,
  output cond_t [NUM_CH-1:0]             condQ,
  output logic [DATA_W-1:0]              dataQ,
  output logic [DATA_W-1:0]              dmaskQ,
  output logic [NUM_CH-1:0]              matchQ
);
  logic [NUM_CH-1:0] hit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ  <= '0;
      dmaskQ <= '0;
    end else begin
      if (strb.wrData)  dataQ  <= wrData;
      if (strb.wrDmask) dmaskQ <= wrData;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam bit HAS = (ch == NUM_CH - 1);
    cond_t condIn;

    always_comb begin
      condIn = cond_t'(wrData[COND_W-1:0]);
      if (!HAS) condIn.dataEn = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrQ[ch]  <= '0;
        maskQ[ch]  <= '0;
        condQ[ch]  <= '0;
        matchQ[ch] <= 1'b0;
      end else begin
        if (strb.wrAddr[ch]) addrQ[ch] <= wrData[ADDR_W-1:0];
        if (strb.wrMask[ch]) maskQ[ch] <= wrData[ADDR_W-1:0];
        if (strb.wrCond[ch]) condQ[ch] <= condIn;
        matchQ[ch] <= busValid && hit[ch];
      end
    end

    bbc_chan_cmp #(
      .ADDR_W  (ADDR_W),
      .HAS_DATA(HAS)
    ) u_cmp (
      .addrReg (addrQ[ch]),
      .maskReg (maskQ[ch]),
      .cond    (condQ[ch]),
      .dataReg (dataQ),
      .dmaskReg(dmaskQ),
      .busAddr (busAddr),
      .busData (busData),
      .busSize (busSize),
      .busFetch(busFetch),
      .busWrite(busWrite),
      .busDma  (busDma),
      .hit     (hit[ch])
    );

    AST_MATCH_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
      matchQ[ch] |-> $past(busValid)) else $error("match without bus cycle"); // R11

    AST_SIZE_MISMATCH_NONE: assert property (@(posedge clk) disable iff (!rstN)
      (busValid && condQ[ch].size != SZ_ANY && condQ[ch].size != busSize) |=> !matchQ[ch])
      else $error("match on wrong size"); // R4

    AST_DMA_LONG_NONE: assert property (@(posedge clk) disable iff (!rstN)
      (busValid && busDma && condQ[ch].size == SZ_LONG) |=> !matchQ[ch])
      else $error("DMA longword matched"); // R10

    AST_CLOSED_KIND_NONE: assert property (@(posedge clk) disable iff (!rstN)
      (busValid && condQ[ch].kind == 2'b00) |=> !matchQ[ch])
      else $error("match with no cycle kind allowed"); // R5
  end

  AST_ANY_SIZE_DATA_NONE: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busFetch && condQ[NUM_CH-1].dataEn && condQ[NUM_CH-1].size == SZ_ANY)
      |=> !matchQ[NUM_CH-1]) else $error("data condition without size matched"); // R8
endmodule

// File: rtl/bbc_ctrl.sv
module bbc_ctrl
  import bbc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWrEn,
  input  logic [REG_AW-1:0]             regAddr,
  input  logic [NUM_CH-1:0]             regWrBits,
  input  logic [NUM_CH-1:0]             matchIn,
  input  logic [NUM_CH-1:0][ADDR_W-1:0] addrQ,
  input  logic [NUM_CH-1:0][ADDR_W-1:0] maskQ,
  input  cond_t [NUM_CH-1:0]            condQ,
  input  logic [DATA_W-1:0]             dataQ,
  input  logic [DATA_W-1:0]             dmaskQ,
  output strobe_t                       strb,
  output logic [DATA_W-1:0]             regRdData
);
  logic [NUM_CH-1:0] statusQ;
  logic [NUM_CH-1:0] clrMask;

  function automatic logic [REG_AW-1:0] offs(input int ch, input int k);
    return REG_AW'(ch * CH_REGS + k);
  endfunction

  always_comb begin
    strb = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      strb.wrAddr[ch] = regWrEn && (regAddr == offs(ch, 0));
      strb.wrMask[ch] = regWrEn && (regAddr == offs(ch, 1));
      strb.wrCond[ch] = regWrEn && (regAddr == offs(ch, 2));
    end
    strb.wrData   = regWrEn && (regAddr == REG_AW'(OFF_DATA));
    strb.wrDmask  = regWrEn && (regAddr == REG_AW'(OFF_DMASK));
    strb.wrStatus = regWrEn && (regAddr == REG_AW'(OFF_STATUS));
  end

  assign clrMask = strb.wrStatus ? ~regWrBits : '0;

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~clrMask) | matchIn;
  end

  always_comb begin
    regRdData = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (regAddr == offs(ch, 0)) regRdData = DATA_W'(addrQ[ch]);
      if (regAddr == offs(ch, 1)) regRdData = DATA_W'(maskQ[ch]);
      if (regAddr == offs(ch, 2)) regRdData = DATA_W'(condQ[ch]);
    end
    if (regAddr == REG_AW'(OFF_DATA))   regRdData = dataQ;
    if (regAddr == REG_AW'(OFF_DMASK))  regRdData = dmaskQ;
    if (regAddr == REG_AW'(OFF_STATUS)) regRdData = DATA_W'(statusQ);
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rstN)
      matchIn[ch] |=> statusQ[ch]) else $error("status not set"); // R12

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (statusQ[ch] && !(strb.wrStatus && !regWrBits[ch])) |=> statusQ[ch])
      else $error("status lost"); // R12
  end
endmodule

// File: rtl/bus_break_cmp.sv
module bus_break_cmp
  import bbc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busData,
  input  logic [1:0]        busSize,
  input  logic              busFetch,
  input  logic              busWrite,
  input  logic              busDma,
  output logic              matchA,
  output logic              matchB
);
  strobe_t                       strb;
  logic [NUM_CH-1:0][ADDR_W-1:0] addrQ;
  logic [NUM_CH-1:0][ADDR_W-1:0] maskQ;
  cond_t [NUM_CH-1:0]            condQ;
  logic [DATA_W-1:0]             dataQ;
  logic [DATA_W-1:0]             dmaskQ;
  logic [NUM_CH-1:0]             matchQ;

  bbc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrBits(regWrData[NUM_CH-1:0]),
    .matchIn  (matchQ),
    .addrQ    (addrQ),
    .maskQ    (maskQ),
    .condQ    (condQ),
    .dataQ    (dataQ),
    .dmaskQ   (dmaskQ),
    .strb     (strb),
    .regRdData(regRdData)
  );

  bbc_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (regWrData),
    .busValid(busValid),
    .busAddr (busAddr),
    .busData (busData),
    .busSize (busSize),
    .busFetch(busFetch),
    .busWrite(busWrite),
    .busDma  (busDma),
    .addrQ   (addrQ),
    .maskQ   (maskQ),
    .condQ   (condQ),
    .dataQ   (dataQ),
    .dmaskQ  (dmaskQ),
    .matchQ  (matchQ)
  );

  assign matchA = matchQ[0];
  assign matchB = matchQ[1];
endmodule

// File: tb/bus_break_cmp_tb.sv
module bus_break_cmp_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        busValid = 1'b0;
  logic [31:0] busAddr = '0;
  logic [31:0] busData = '0;
  logic [1:0]  busSize = '0;
  logic        busFetch = 1'b0;
  logic        busWrite = 1'b0;
  logic        busDma = 1'b0;
  logic        matchA;
  logic        matchB;

  int checks = 0;
  int failures = 0;

  localparam logic [1:0] ANY = 2'b00, BY = 2'b01, WD = 2'b10, LG = 2'b11;

  bus_break_cmp u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .busValid(busValid),
    .busAddr(busAddr), .busData(busData), .busSize(busSize),
    .busFetch(busFetch), .busWrite(busWrite), .busDma(busDma),
    .matchA(matchA), .matchB(matchB)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] cnd(input logic [1:0] sz, input logic [1:0] kind,
                                      input logic [1:0] dir, input logic [1:0] mst,
                                      input logic den);
    return {23'b0, den, mst, dir, kind, sz};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  // one bus cycle; returns {matchB, matchA} sampled one clock later
  task automatic cyc(input logic v, input logic [31:0] a, input logic [31:0] d,
                     input logic [1:0] sz, input logic f, input logic w,
                     input logic dm, output logic [1:0] m);
    @(negedge clk);
    busValid = v; busAddr = a; busData = d; busSize = sz;
    busFetch = f; busWrite = w; busDma = dm;
    @(negedge clk);
    m = {matchB, matchA};
    busValid = 1'b0;
  endtask

  task automatic expect2(input string tag, input logic [31:0] a, input logic [31:0] d,
                         input logic [1:0] sz, input logic f, input logic w,
                         input logic dm, input logic [1:0] exp);
    logic [1:0] m;
    cyc(1'b1, a, d, sz, f, w, dm, m);
    chk(tag, {30'b0, m}, {30'b0, exp});
  endtask

  task automatic clearChannels();
    wr(4'd2, 32'd0); wr(4'd5, 32'd0); wr(4'd1, 32'd0); wr(4'd4, 32'd0);
    wr(4'd7, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    logic [1:0] m;
    for (int i = 0; i < 9; i++) begin
      rd(4'(i), d);
      chk("R13 reset readback", d, 32'd0);
    end
    chk("R11 reset match", {30'b0, matchB, matchA}, 32'd0);
    expect2("R13 zero condition", 32'd0, 32'd0, LG, 1'b0, 1'b0, 1'b0, 2'b00);
    wr(4'd2, 32'h1FF);
    rd(4'd2, d);
    chk("R13 channel A cond bit8", d, 32'h0FF);
    wr(4'd0, 32'h1234_5678);
    rd(4'd0, d);
    chk("R13 addr readback", d, 32'h1234_5678);
    wr(4'd6, 32'hCAFE_F00D);
    rd(4'd6, d);
    chk("R13 data readback", d, 32'hCAFE_F00D);
    cyc(1'b0, 32'h1234_5678, 0, BY, 1'b0, 1'b0, 1'b0, m);
    chk("R11 no valid", {30'b0, m}, 32'd0);
  endtask

  task automatic t_sizeAlign();
    wr(4'd0, 32'h1000_0004);
    wr(4'd2, cnd(ANY, 2'b11, 2'b11, 2'b11, 1'b0));
    expect2("R1 long ignores 1..0", 32'h1000_0007, 0, LG, 0, 0, 0, 2'b01);
    expect2("R1 word ignores 0", 32'h1000_0005, 0, WD, 0, 0, 0, 2'b01);
    expect2("R1 word bit1 counts", 32'h1000_0006, 0, WD, 0, 0, 0, 2'b00);
    expect2("R1 byte exact", 32'h1000_0004, 0, BY, 0, 0, 0, 2'b01);
    expect2("R1 byte bit0 counts", 32'h1000_0005, 0, BY, 0, 0, 0, 2'b00);
    expect2("R1 size 00 bus", 32'h1000_0004, 0, ANY, 0, 0, 0, 2'b00);
  endtask

  task automatic t_example();
    wr(4'd0, 32'h0000_1003);
    expect2("R2 long 1000", 32'h1000, 0, LG, 0, 0, 0, 2'b01);
    expect2("R2 word 1002", 32'h1002, 0, WD, 0, 0, 0, 2'b01);
    expect2("R2 byte 1003", 32'h1003, 0, BY, 0, 0, 0, 2'b01);
    expect2("R2 byte 1002", 32'h1002, 0, BY, 0, 0, 0, 2'b00);
    expect2("R2 word 1000", 32'h1000, 0, WD, 0, 0, 0, 2'b00);
  endtask

  task automatic t_mask();
    wr(4'd0, 32'h0000_2000);
    wr(4'd1, 32'h0000_00F0);
    expect2("R3 masked bits", 32'h20A0, 0, BY, 0, 0, 0, 2'b01);
    expect2("R3 unmasked bit", 32'h2100, 0, BY, 0, 0, 0, 2'b00);
    wr(4'd1, 32'd0);
  endtask

  task automatic t_sizeCond();
    wr(4'd0, 32'h0000_4000);
    wr(4'd2, cnd(WD, 2'b11, 2'b11, 2'b11, 1'b0));
    expect2("R4 byte rejected", 32'h4000, 0, BY, 0, 0, 0, 2'b00);
    expect2("R4 word accepted", 32'h4000, 0, WD, 0, 0, 0, 2'b01);
    expect2("R4 long rejected", 32'h4000, 0, LG, 0, 0, 0, 2'b00);
  endtask

  task automatic t_attrs();
    wr(4'd2, cnd(ANY, 2'b01, 2'b11, 2'b11, 1'b0));
    expect2("R5 data blocked", 32'h4000, 0, LG, 0, 0, 0, 2'b00);
    expect2("R5 fetch allowed", 32'h4000, 0, LG, 1, 0, 0, 2'b01);
    wr(4'd2, cnd(ANY, 2'b11, 2'b10, 2'b11, 1'b0));
    expect2("R5 read blocked", 32'h4000, 0, LG, 0, 0, 0, 2'b00);
    expect2("R5 write allowed", 32'h4000, 0, LG, 0, 1, 0, 2'b01);
    wr(4'd2, cnd(ANY, 2'b11, 2'b11, 2'b10, 1'b0));
    expect2("R5 cpu blocked", 32'h4000, 0, LG, 0, 0, 0, 2'b00);
    expect2("R5 dma allowed", 32'h4000, 0, WD, 0, 0, 1, 2'b01);
    wr(4'd2, 32'd0);
  endtask

  task automatic t_dataLongWord();
    wr(4'd3, 32'h0000_3000);
    wr(4'd6, 32'hDEAD_BEEF);
    wr(4'd5, cnd(LG, 2'b11, 2'b11, 2'b11, 1'b1));
    expect2("R6 long data equal", 32'h3000, 32'hDEAD_BEEF, LG, 0, 0, 0, 2'b10);
    expect2("R6 long data differ", 32'h3000, 32'hDEAD_BEEE, LG, 0, 0, 0, 2'b00);
    wr(4'd7, 32'h0000_0001);
    expect2("R6 data mask bit", 32'h3000, 32'hDEAD_BEEE, LG, 0, 0, 0, 2'b10);
    wr(4'd7, 32'd0);
    wr(4'd3, 32'h0000_3002);
    wr(4'd6, 32'hFFFF_1234);
    wr(4'd5, cnd(WD, 2'b11, 2'b11, 2'b11, 1'b1));
    expect2("R6 word upper lane", 32'h3002, 32'h1234_0000, WD, 0, 0, 0, 2'b10);
    expect2("R6 word wrong lane", 32'h3002, 32'h0000_1234, WD, 0, 0, 0, 2'b00);
    wr(4'd3, 32'h0000_3000);
    expect2("R6 word lower lane", 32'h3000, 32'h0000_1234, WD, 0, 0, 0, 2'b10);
  endtask

  task automatic t_dataByte();
    wr(4'd6, 32'h0000_1122);
    wr(4'd5, cnd(BY, 2'b11, 2'b11, 2'b11, 1'b1));
    wr(4'd3, 32'h0000_3001);
    expect2("R7 lane1 high byte", 32'h3001, 32'h0000_1100, BY, 0, 0, 0, 2'b10);
    expect2("R7 lane1 low byte no", 32'h3001, 32'h0000_2200, BY, 0, 0, 0, 2'b00);
    wr(4'd3, 32'h0000_3003);
    expect2("R7 lane3 high byte", 32'h3003, 32'h1100_0000, BY, 0, 0, 0, 2'b10);
    wr(4'd3, 32'h0000_3002);
    expect2("R7 lane2 low byte", 32'h3002, 32'h0022_0000, BY, 0, 0, 0, 2'b10);
    expect2("R7 lane2 high byte no", 32'h3002, 32'h0011_0000, BY, 0, 0, 0, 2'b00);
  endtask

  task automatic t_anyData();
    wr(4'd3, 32'h0000_3000);
    wr(4'd6, 32'h0000_1234);
    wr(4'd5, cnd(ANY, 2'b11, 2'b11, 2'b11, 1'b1));
    expect2("R8 any size data", 32'h3000, 32'h0000_1234, LG, 0, 0, 0, 2'b00);
  endtask

  task automatic t_fetch();
    wr(4'd5, cnd(LG, 2'b11, 2'b11, 2'b11, 1'b1));
    wr(4'd6, 32'hDEAD_BEEF);
    expect2("R9 fetch skips data", 32'h3000, 32'h0, LG, 1, 0, 0, 2'b10);
    expect2("R9 data cycle checks", 32'h3000, 32'h0, LG, 0, 0, 0, 2'b00);
  endtask

  task automatic t_dma();
    wr(4'd0, 32'h0000_5000);
    wr(4'd2, cnd(LG, 2'b11, 2'b11, 2'b11, 1'b0));
    expect2("R10 dma long addr", 32'h5000, 0, LG, 0, 0, 1, 2'b00);
    expect2("R10 cpu long addr", 32'h5000, 0, LG, 0, 0, 0, 2'b01);
    wr(4'd2, 32'd0);
    wr(4'd6, 32'h0000_1234);
    wr(4'd5, cnd(LG, 2'b11, 2'b11, 2'b11, 1'b1));
    expect2("R10 dma long data", 32'h3000, 32'h0000_1234, LG, 0, 0, 1, 2'b00);
    expect2("R10 cpu long data", 32'h3000, 32'h0000_1234, LG, 0, 0, 0, 2'b10);
    wr(4'd5, cnd(WD, 2'b11, 2'b11, 2'b11, 1'b1));
    expect2("R10 dma word data", 32'h3000, 32'h0000_1234, WD, 0, 0, 1, 2'b10);
  endtask

  task automatic t_pulse();
    logic [1:0] m;
    wr(4'd0, 32'h0000_6000);
    wr(4'd2, cnd(ANY, 2'b11, 2'b11, 2'b11, 1'b0));
    expect2("R11 pulse high", 32'h6000, 0, BY, 0, 0, 0, 2'b01);
    @(negedge clk);
    chk("R11 pulse one clock", {31'b0, matchA}, 32'd0);
    cyc(1'b0, 32'h6000, 0, BY, 0, 0, 0, m);
    chk("R11 valid low", {30'b0, m}, 32'd0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    wr(4'd8, 32'd0);
    rd(4'd8, d);
    chk("R12 cleared", d, 32'd0);
    expect2("R12 A hit", 32'h6000, 0, BY, 0, 0, 0, 2'b01);
    rd(4'd8, d);
    chk("R12 A set", d, 32'd1);
    wr(4'd2, 32'd0);
    wr(4'd5, cnd(WD, 2'b11, 2'b11, 2'b11, 1'b1));
    expect2("R12 B hit", 32'h3000, 32'h0000_1234, WD, 0, 0, 0, 2'b10);
    rd(4'd8, d);
    chk("R12 both set", d, 32'd3);
    wr(4'd8, 32'd2);
    rd(4'd8, d);
    chk("R12 write 1 keeps", d, 32'd2);
    wr(4'd8, 32'd0);
    rd(4'd8, d);
    chk("R12 write 0 clears", d, 32'd0);
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog R11 actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    clearChannels();
    t_sizeAlign();
    t_example();
    t_mask();
    t_sizeCond();
    t_attrs();
    clearChannels();
    t_dataLongWord();
    t_dataByte();
    t_anyData();
    t_fetch();
    t_dma();
    clearChannels();
    t_pulse();
    t_status();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule